// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Level and Character Timeout

This block is the receive-side buffer of a 16550-style serial port. It sits between a receive shifter, which hands it one byte or one break event per clock, and the register decoder of the host bus, which pulses a data-read or a status-read strobe. In queued mode, received bytes go into a 16-entry circular buffer. In single-register mode, one holding byte is overwritten by each arrival.

The block keeps the host-visible receive status: data ready, overrun and break. It also raises a flag when the queue holds at least the selected trigger level, and a character-timeout flag when data has sat unread for four frame times. The frame time is worked out from the programmed frame format and the bit-rate divisor. The timer counts bit ticks, and each bit tick lasts `divisor` clocks.

Top module: `uart_rx_buffer`

## Requirements
- R1: In queued mode (`fifo_en_i`=1), bytes are returned by data reads in arrival order, and up to 16 bytes are held. `rd_byte_o` shows the oldest byte and is 0 when the queue is empty.
- R2: In queued mode, `trig_hit_o` is 1 when the held count is at least the level chosen by `trig_sel_i`: 0→1, 1→4, 2→8, 3→14 bytes. In single-register mode `trig_hit_o` equals `data_ready_o`.
- R3: A byte arriving while the queue holds 16 bytes, with no read in the same cycle, is discarded. The held contents are kept and `overrun_o` is set.
- R4: A break event (`brk_i`) stores a zero byte, as a received byte would be stored, and sets both `break_o` and `data_ready_o`. If the break and `rx_valid_i` come together, the break wins.
- R5: A data read of an empty queue returns 0. A data read that leaves the queue empty clears `data_ready_o` and `break_o`.
- R6: Each queued arrival, and each data read that leaves bytes behind, restarts a timer of four frame times. When the timer expires with bytes held, `timeout_o` is set. Any data read clears `timeout_o`.
- R7: Frame length in bit ticks = 1 + (`data_len_i`+5) + `parity_en_i` + (1 + `two_stop_i`). A bit tick is `divisor_i` clocks, and a divisor of 0 acts as 1. `timeout_o` rises exactly 4·frame·divisor clock edges after the restarting edge.
- R8: In single-register mode, a new byte replaces the held byte. `overrun_o` is set if `data_ready_o` was already 1 and no data read happened in the same cycle. A data read returns the held byte and clears `data_ready_o` and `break_o`.
- R9: A `flush_i` pulse, or any change of `fifo_en_i`, empties the queue and clears `data_ready_o`, `break_o`, `timeout_o` and the timer in the next cycle. An arrival in that same cycle is dropped. `overrun_o` is not affected.
- R10: A status read (`rd_status_i`) clears `break_o` and `overrun_o`. A break or an overflowing arrival in the same cycle sets its bit again.
- R11: A data read and an arrival in the same cycle remove the oldest byte and append the new one. On a full queue this causes no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | 1 = queued mode, 0 = single-register mode |
| trig_sel_i | input | 2 | Trigger level select |
| flush_i | input | 1 | Pulse: empty the queue and clear status |
| data_len_i | input | 2 | Data bits minus 5 |
| parity_en_i | input | 1 | Frame carries a parity bit |
| two_stop_i | input | 1 | Frame carries two stop bits |
| divisor_i | input | DIV_W | Clocks per bit tick |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| brk_i | input | 1 | Break event strobe |
| rd_data_i | input | 1 | Host data-read strobe |
| rd_status_i | input | 1 | Host status-read strobe |
| rd_byte_o | output | 8 | Byte the next data read returns |
| data_ready_o | output | 1 | Data ready |
| overrun_o | output | 1 | Overrun |
| break_o | output | 1 | Break received |
| trig_hit_o | output | 1 | Count at or above trigger level |
| timeout_o | output | 1 | Character timeout |

## Verification
Two pairs of functions can land on the same clock edge. One is a host data read with an arrival; the other is a status read with an overflowing arrival. The bench drives both strobes in one cycle on a full queue. It checks that the first read/arrival pair leaves no overrun, and that the arrival order seen in the following reads is the expected one. It checks that the status-read/overflow pair leaves `overrun_o` set and that a later lone status read clears it. For the timeout, the bench sweeps all sixteen frame formats under several divisors. Each expected rise edge is computed from the frame-length formula, and the flag is sampled one edge before that edge and on it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Host-visible receive state held by the top level.
    typedef struct packed {
        logic       fifo_en;
        logic [7:0] hold;
        logic       dr;
        logic       oe;
        logic       bi;
        logic       to;
    } rxq_state_t;

    // Trigger level in bytes for the two select bits.
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    // Bits in one frame: start + data + parity + stop.
    function automatic logic [3:0] frame_bits(input logic [1:0] len,
                                              input logic       par,
                                              input logic       stop2);
        return 4'd7 + {2'b00, len} + {3'b000, par} + {3'b000, stop2};
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         push_i,
    input  logic [W-1:0]                 data_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 head_o,
    output logic [$clog2(DEPTH):0]       count_o,
    output logic                         drop_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          p_d, p_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic          pop_ok, push_ok, empty, full;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (p_q.cnt == '0);
        full    = (p_q.cnt == CW'(DEPTH));
        pop_ok  = pop_i && !empty && !clr_i;
        push_ok = push_i && !clr_i && (!full || pop_ok);
        drop_o  = push_i && !clr_i && full && !pop_ok;
        head_o  = empty ? '0 : mem_q[p_q.rd];
        count_o = p_q.cnt;

        p_d = p_q;
        if (clr_i) begin
            p_d = '0;
        end else begin
            if (pop_ok)  p_d.rd = bump(p_q.rd);
            if (push_ok) p_d.wr = bump(p_q.wr);
            case ({push_ok, pop_ok})
                2'b10:   p_d.cnt = p_q.cnt + 1'b1;
                2'b01:   p_d.cnt = p_q.cnt - 1'b1;
                default: p_d.cnt = p_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[p_q.wr] <= data_i;
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.cnt <= CW'(DEPTH));

    p_pushpop_keeps_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty && !clr_i) |=> $stable(p_q.cnt));

    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));

endmodule

// File: rtl/rxq_chartime.sv
module rxq_chartime
    import rxq_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic [1:0]       data_len_i,
    input  logic             parity_en_i,
    input  logic             two_stop_i,
    input  logic             restart_i,
    input  logic             cancel_i,
    output logic             expire_o
);
    localparam int TW       = 6;
    localparam int MAX_LOAD = 48;

    typedef struct packed {
        logic             armed;
        logic [DIV_W-1:0] presc;
        logic [TW-1:0]    left;
    } ct_t;

    ct_t              c_d, c_q;
    logic [DIV_W-1:0] div_eff;
    logic             tick;
    logic [TW-1:0]    load;

    always_comb begin
        div_eff  = (divisor_i == '0) ? DIV_W'(1) : divisor_i;
        load     = {frame_bits(data_len_i, parity_en_i, two_stop_i), 2'b00};
        tick     = c_q.armed && (c_q.presc == div_eff - 1'b1);
        expire_o = tick && (c_q.left == TW'(1)) && !restart_i && !cancel_i;

        c_d = c_q;
        if (cancel_i) begin
            c_d = '0;
        end else if (restart_i) begin
            c_d.armed = 1'b1;
            c_d.presc = '0;
            c_d.left  = load;
        end else if (c_q.armed) begin
            if (tick) begin
                c_d.presc = '0;
                c_d.left  = c_q.left - 1'b1;
                if (c_q.left == TW'(1)) c_d.armed = 1'b0;
            end else begin
                c_d.presc = c_q.presc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    p_load_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.armed |-> (c_q.left != '0) && (c_q.left <= TW'(MAX_LOAD)));

    p_restart_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !cancel_i) |=> c_q.armed && (c_q.presc == '0));

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             flush_i,
    input  logic [1:0]       data_len_i,
    input  logic             parity_en_i,
    input  logic             two_stop_i,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             rx_valid_i,
    input  logic [7:0]       rx_byte_i,
    input  logic             brk_i,
    input  logic             rd_data_i,
    input  logic             rd_status_i,
    output logic [7:0]       rd_byte_o,
    output logic             data_ready_o,
    output logic             overrun_o,
    output logic             break_o,
    output logic             trig_hit_o,
    output logic             timeout_o
);
    localparam int CW = $clog2(DEPTH) + 1;

    rxq_state_t    s_d, s_q;
    logic          clr, rx_evt, qmode;
    logic [7:0]    rx_val, head;
    logic [CW-1:0] cnt;
    logic          drop, expire, restart, cancel;
    logic          st_push, st_pop;

    always_comb begin
        qmode   = s_q.fifo_en;
        clr     = flush_i || (fifo_en_i != s_q.fifo_en);
        rx_evt  = rx_valid_i || brk_i;
        rx_val  = brk_i ? 8'h00 : rx_byte_i;
        st_push = qmode && rx_evt;
        st_pop  = qmode && rd_data_i;
        restart = qmode && !clr &&
                  (rx_evt || (rd_data_i && cnt > CW'(1)));
        cancel  = clr || !qmode;
    end

    rxq_store #(.DEPTH(DEPTH), .W(8)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .push_i  (st_push),
        .data_i  (rx_val),
        .pop_i   (st_pop),
        .head_o  (head),
        .count_o (cnt),
        .drop_o  (drop)
    );

    rxq_chartime #(.DIV_W(DIV_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .divisor_i   (divisor_i),
        .data_len_i  (data_len_i),
        .parity_en_i (parity_en_i),
        .two_stop_i  (two_stop_i),
        .restart_i   (restart),
        .cancel_i    (cancel),
        .expire_o    (expire)
    );

    always_comb begin
        s_d         = s_q;
        s_d.fifo_en = fifo_en_i;

        if (rd_status_i) begin
            s_d.oe = 1'b0;
            s_d.bi = 1'b0;
        end

        if (clr) begin
            s_d.dr = 1'b0;
            s_d.bi = 1'b0;
            s_d.to = 1'b0;
        end else if (qmode) begin
            if (rd_data_i) begin
                s_d.to = 1'b0;
                if (cnt <= CW'(1)) begin
                    s_d.dr = 1'b0;
                    s_d.bi = 1'b0;
                end
            end
            if (rx_evt) begin
                s_d.dr = 1'b1;
                if (brk_i) s_d.bi = 1'b1;
                if (drop)  s_d.oe = 1'b1;
            end
            if (expire && (cnt != '0) && !rd_data_i) s_d.to = 1'b1;
        end else begin
            if (rd_data_i) begin
                s_d.dr = 1'b0;
                s_d.bi = 1'b0;
            end
            if (rx_evt) begin
                s_d.hold = rx_val;
                if (s_q.dr && !rd_data_i) s_d.oe = 1'b1;
                s_d.dr = 1'b1;
                if (brk_i) s_d.bi = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_byte_o    = qmode ? head : s_q.hold;
        data_ready_o = s_q.dr;
        overrun_o    = s_q.oe;
        break_o      = s_q.bi;
        timeout_o    = s_q.to;
        trig_hit_o   = qmode ? (cnt >= CW'(trig_level(trig_sel_i))) : s_q.dr;
    end

    p_trig_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit_o |-> data_ready_o);

    p_full_drop_sets_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (qmode && rx_evt && !rd_data_i && !clr && cnt == CW'(DEPTH)) |=> overrun_o);

    p_break_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i && !clr) |=> (break_o && data_ready_o));

    p_empty_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (qmode && rd_data_i && cnt <= CW'(1) && !rx_evt && !clr)
            |=> (!data_ready_o && !break_o));

    p_timeout_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (cnt != '0));

    p_read_clears_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_i |=> !timeout_o);

    p_single_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!qmode && !clr && rx_evt && data_ready_o && !rd_data_i) |=> overrun_o);

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!data_ready_o && !break_o && !timeout_o));

    p_status_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status_i && !rx_evt) |=> (!overrun_o && !break_o));

endmodule

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic [1:0]  trig_sel = 2'd0;
    logic        flush = 1'b0;
    logic [1:0]  data_len = 2'd3;
    logic        parity_en = 1'b0;
    logic        two_stop = 1'b0;
    logic [15:0] divisor = 16'd256;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        brk = 1'b0;
    logic        rd_data = 1'b0;
    logic        rd_status = 1'b0;
    logic [7:0]  rd_byte;
    logic        data_ready, overrun, break_f, trig_hit, timeout;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_buffer #(.DEPTH(DEPTH), .DIV_W(16)) i_uart_rx_buffer (
        .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en), .trig_sel_i(trig_sel),
        .flush_i(flush), .data_len_i(data_len), .parity_en_i(parity_en),
        .two_stop_i(two_stop), .divisor_i(divisor), .rx_valid_i(rx_valid),
        .rx_byte_i(rx_byte), .brk_i(brk), .rd_data_i(rd_data),
        .rd_status_i(rd_status), .rd_byte_o(rd_byte), .data_ready_o(data_ready),
        .overrun_o(overrun), .break_o(break_f), .trig_hit_o(trig_hit),
        .timeout_o(timeout)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b; tick(); rx_valid = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        b = rd_byte; rd_data = 1'b1; tick(); rd_data = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1; tick(); flush = 1'b0;
    endtask

    task automatic status_read();
        rd_status = 1'b1; tick(); rd_status = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] b;
        int lvl, frame, dv;

        tick(2);
        rst_n = 1'b1;
        tick();
        // reset state
        check("R5 reset dr", data_ready, 0);
        check("R10 reset oe", overrun, 0);
        check("R4 reset bi", break_f, 0);
        check("R6 reset to", timeout, 0);
        check("R2 reset trig", trig_hit, 0);

        fifo_en = 1'b1; tick();

        // R2 trigger sweep, R1 order, R3 overflow
        for (int sel = 0; sel < 4; sel++) begin
            trig_sel = 2'(sel);
            lvl = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
            do_flush();
            for (int n = 1; n <= DEPTH; n++) begin
                push(8'(n + 16 * sel));
                check("R2 trigger level", trig_hit, (n >= lvl) ? 1 : 0);
            end
            if (sel == 0) begin
                check("R3 no overrun at full", overrun, 0);
                push(8'hEE);
                check("R3 overrun on full", overrun, 1);
                check("R3 contents kept", rd_byte, 1);
            end
            for (int n = 1; n <= DEPTH; n++) begin
                read_byte(b);
                check("R1 arrival order", b, n + 16 * sel);
            end
            check("R5 dr cleared when emptied", data_ready, 0);
            read_byte(b);
            check("R5 empty read value", b, 0);
        end
        check("R3 overrun persists", overrun, 1);
        status_read();
        check("R10 status clears oe", overrun, 0);

        // R4 break
        do_flush();
        push(8'h11);
        brk = 1'b1; tick(); brk = 1'b0;
        check("R4 break flag", break_f, 1);
        check("R4 break dr", data_ready, 1);
        read_byte(b);
        check("R4 first byte", b, 8'h11);
        check("R5 break held while data", break_f, 1);
        read_byte(b);
        check("R4 break byte zero", b, 0);
        check("R5 read clears break", break_f, 0);
        brk = 1'b1; tick(); brk = 1'b0;
        status_read();
        check("R10 status clears break", break_f, 0);
        check("R10 status leaves dr", data_ready, 1);
        read_byte(b);

        // R6/R7 timeout sweep
        for (int d = 0; d < 3; d++) begin
            dv = (d == 0) ? 0 : (d == 1) ? 1 : 3;
            for (int l = 0; l < 16; l++) begin
                data_len = l[1:0]; two_stop = l[2]; parity_en = l[3];
                divisor = 16'(dv);
                frame = 1 + 5 + l[1:0] + l[3] + 1 + l[2];
                do_flush();
                push(8'h5A);
                tick(4 * frame * ((dv == 0) ? 1 : dv) - 1);
                check("R7 timeout not early", timeout, 0);
                tick();
                check("R7 timeout on time", timeout, 1);
                read_byte(b);
                check("R6 read clears timeout", timeout, 0);
            end
        end

        // R6 restart by read leaving data
        data_len = 2'd0; parity_en = 1'b0; two_stop = 1'b0; divisor = 16'd2;
        do_flush();
        push(8'h21); push(8'h22);
        tick(20);
        read_byte(b);
        tick(55);
        check("R6 read restarts timer", timeout, 0);
        tick();
        check("R6 expiry after restart", timeout, 1);
        do_flush();
        check("R9 flush clears timeout", timeout, 0);
        check("R9 flush clears dr", data_ready, 0);
        check("R9 flush empties", rd_byte, 0);
        tick(70);
        check("R9 flush cancels timer", timeout, 0);

        divisor = 16'd256;
        // R9 enable change, R8 single mode
        push(8'h44);
        fifo_en = 1'b0; tick();
        check("R9 mode change clears dr", data_ready, 0);
        push(8'h31);
        check("R8 single dr", data_ready, 1);
        check("R8 single value", rd_byte, 8'h31);
        check("R2 single trig", trig_hit, 1);
        check("R8 no overrun first", overrun, 0);
        push(8'h32);
        check("R8 replaced", rd_byte, 8'h32);
        check("R8 overrun set", overrun, 1);
        status_read();
        check("R10 single status clears", overrun, 0);
        read_byte(b);
        check("R8 read value", b, 8'h32);
        check("R8 read clears dr", data_ready, 0);
        brk = 1'b1; tick(); brk = 1'b0;
        check("R4 single break value", rd_byte, 0);
        check("R4 single break flag", break_f, 1);
        fifo_en = 1'b1; tick();
        check("R9 enable clears break", break_f, 0);
        check("R9 enable clears dr", data_ready, 0);

        // R10 collision: status read with overflowing arrival
        for (int n = 1; n <= DEPTH; n++) push(8'(n));
        rd_status = 1'b1; rx_valid = 1'b1; rx_byte = 8'hAB; tick();
        rd_status = 1'b0; rx_valid = 1'b0;
        check("R10 same-cycle overrun wins", overrun, 1);
        status_read();
        check("R10 lone status clears", overrun, 0);

        // R11 collision: read and arrival on a full queue
        b = rd_byte;
        rd_data = 1'b1; rx_valid = 1'b1; rx_byte = 8'h77; tick();
        rd_data = 1'b0; rx_valid = 1'b0;
        check("R11 popped head", b, 1);
        check("R11 no overrun", overrun, 0);
        for (int n = 2; n <= DEPTH; n++) begin
            read_byte(b);
            check("R11 order after", b, n);
        end
        read_byte(b);
        check("R11 appended byte", b, 8'h77);
        check("R11 empty after", data_ready, 0);
        rd_data = 1'b1; rx_valid = 1'b1; rx_byte = 8'h66; tick();
        rd_data = 1'b0; rx_valid = 1'b0;
        check("R11 empty pop keeps byte", rd_byte, 8'h66);
        check("R11 empty pop dr", data_ready, 1);

        summary();
    end
endmodule